// File: doc/BRIEF.md
# Single-Instruction Conditional Grid Cell

This block is one compute cell for a grid of identical cells that run in lockstep. The cell stores exactly one 32-bit conditional instruction and executes it again on every clock step while it is enabled. There is no program counter and no instruction memory. Each step, two operands are compared. The result of the comparison picks one of two register-to-register operations, and the cell performs only that one.

The cell has four local data registers, numbered 0 to 3. Register numbers 4 to 7 do not address storage. They address the cell's four neighbour links instead. Reading a link consumes the value the neighbour has presented on it. Writing a link places the result on the outgoing side of that link, and the value is held there until the neighbour accepts it. A step fires only when every link input it needs is present and its destination link (if any) is empty. Otherwise the cell waits and never uses stale data.

A host sets the cell up through a small register port while the cell is halted. It loads the data registers and the program word, starts the cell, then halts it and reads the results back.

Top module: `cond_cell`

## Requirements
- R1: After reset the cell is halted, registers 0 to 3 read 0, the program register reads 0x0000003F (both opcodes no-op), and every `link_out_valid` and `link_in_ready` bit is 0.
- R2: While `run_en` is 0, a host write with `host_we` high updates register 0 to 3 for `host_addr` 0 to 3, or the program register for `host_addr` 8. `host_rdata` returns the selected register combinationally, and returns 0 for any other address.
- R3: While `run_en` is 1, host writes change no register, including the program register.
- R4: Program word layout: bits [31:30] test, [29:27] Ra, [26:24] Rb, [23:21] Rc, [20:18] Rd, [17:15] Re, [14:12] Rf, [11:9] Rg, [8:6] Rh, [5:3] THEN opcode, [2:0] ELSE opcode. The test codes are 00 Ra==Rb, 01 Ra<Rb, 10 Ra>Rb and 11 Ra!=Rb, and all comparisons are signed two's complement. When the test is true the step performs Rc = Rd op Re; otherwise it performs Rf = Rg op Rh.
- R5: Opcodes 000 add, 001 subtract, 010 multiply (low 32 bits), 011 AND, 100 OR and 101 XOR all compute on 32-bit values that wrap.
- R6: Opcode 110 copies the first source (Rd or Rg) to the destination. Opcode 111 reads nothing and writes nothing.
- R7: While `run_en` is 1, the stored instruction fires once on every clock cycle in which its operands and destination are ready.
- R8: All operands of a step are read before its result is written, so an instruction that reads its own destination sees the value from before the step.
- R9: A step that needs link k (register 4+k) as an operand waits until `link_in_valid[k]` is 1. In the cycle it fires it raises `link_in_ready[k]`, which consumes the value. `link_in_ready` is never high for a link whose valid is low.
- R10: A result written to register 4+k appears on `link_out_data[k]`, and `link_out_valid[k]` is set on the next clock. Both hold until a cycle with `link_out_ready[k]` high. While the link is occupied, a step that targets it does not fire.
- R11: While `run_en` is 0 the cell performs no step: it consumes no link input and raises no new link output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run_en | input | 1 | 1 runs the stored instruction, 0 halts the cell |
| host_addr | input | 4 | Host register select (0-3 data, 8 program) |
| host_wdata | input | 32 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_rdata | output | 32 | Host read data for `host_addr` |
| link_in_data | input | 128 | Incoming value for each of the four links, 32 bits per link |
| link_in_valid | input | 4 | Neighbour presents a value on the link |
| link_in_ready | output | 4 | Cell consumes the presented value this cycle |
| link_out_data | output | 128 | Outgoing value for each link, 32 bits per link |
| link_out_valid | output | 4 | Outgoing value is pending |
| link_out_ready | input | 4 | Neighbour accepts the pending outgoing value |

## Verification
The assertions assume the neighbours follow the handshake. A neighbour keeps `link_in_valid` and its data steady until it sees `link_in_ready` at a clock edge. `link_out_ready` may arrive at any time. The bench's link stubs raise valid only at falling edges and drop it only after the consuming edge. The bench changes `run_en` only between steps, so each run window spans an exact number of firing edges. All register and program loads are done while the cell is halted, except the writes that deliberately probe R3.

// File: rtl/cell_pkg.sv
package cell_pkg;

  localparam int INSTR_W = 32;
  localparam int SEL_W   = 3;

  typedef enum logic [1:0] {
    TST_EQ = 2'b00,
    TST_LT = 2'b01,
    TST_GT = 2'b10,
    TST_NE = 2'b11
  } tst_e;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_MUL  = 3'b010,
    OP_AND  = 3'b011,
    OP_OR   = 3'b100,
    OP_XOR  = 3'b101,
    OP_PASS = 3'b110,
    OP_NOP  = 3'b111
  } op_e;

  typedef struct packed {
    tst_e             tst;
    logic [SEL_W-1:0] ra;
    logic [SEL_W-1:0] rb;
    logic [SEL_W-1:0] rc;
    logic [SEL_W-1:0] rd;
    logic [SEL_W-1:0] re;
    logic [SEL_W-1:0] rf;
    logic [SEL_W-1:0] rg;
    logic [SEL_W-1:0] rh;
    op_e              then_op;
    op_e              else_op;
  } instr_t;

  localparam logic [INSTR_W-1:0] IDLE_WORD = 32'h0000_003F;

  function automatic logic op_uses_first(op_e op);
    return op != OP_NOP;
  endfunction

  function automatic logic op_uses_second(op_e op);
    return (op != OP_NOP) && (op != OP_PASS);
  endfunction

endpackage

// File: rtl/cell_alu.sv
module cell_alu
  import cell_pkg::*;
#(
  parameter int DW = 32
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = a * b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = a;
    endcase
  end

endmodule

// File: rtl/cell_opsel.sv
module cell_opsel
  import cell_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREG  = 4,
  parameter int NLINK = 4
) (
  input  logic [SEL_W-1:0]     idx,
  input  logic [NREG*DW-1:0]   reg_flat,
  input  logic [NLINK*DW-1:0]  lin_data,
  input  logic [NLINK-1:0]     lin_valid,
  output logic [DW-1:0]        val,
  output logic                 vld
);

  always_comb begin
    val = '0;
    vld = 1'b0;
    for (int k = 0; k < NREG; k++) begin
      if (idx == SEL_W'(k)) begin
        val = reg_flat[k*DW +: DW];
        vld = 1'b1;
      end
    end
    for (int k = 0; k < NLINK; k++) begin
      if (idx == SEL_W'(NREG + k)) begin
        val = lin_data[k*DW +: DW];
        vld = lin_valid[k];
      end
    end
  end

endmodule

// File: rtl/cell_link_out.sv
module cell_link_out #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data
);

  logic          valid_d;
  logic [DW-1:0] data_d;
  logic          upd_en;

  always_comb begin
    valid_d = valid;
    data_d  = data;
    if (load) begin
      valid_d = 1'b1;
      data_d  = load_data;
    end else if (valid && ready) begin
      valid_d = 1'b0;
    end
  end

  assign upd_en = load || (valid && ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (upd_en) begin
      valid <= valid_d;
      data  <= data_d;
    end
  end

endmodule

// File: rtl/cond_cell.sv
module cond_cell
  import cell_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREG  = 4,
  parameter int NLINK = 4,
  parameter int AW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic [AW-1:0]       host_addr,
  input  logic [DW-1:0]       host_wdata,
  input  logic                host_we,
  output logic [DW-1:0]       host_rdata,
  input  logic [NLINK*DW-1:0] link_in_data,
  input  logic [NLINK-1:0]    link_in_valid,
  output logic [NLINK-1:0]    link_in_ready,
  output logic [NLINK*DW-1:0] link_out_data,
  output logic [NLINK-1:0]    link_out_valid,
  input  logic [NLINK-1:0]    link_out_ready
);

  localparam int            NSLOT     = 4;
  localparam logic [AW-1:0] PROG_ADDR = AW'(8);

  // Architectural state
  logic [DW-1:0]      reg_q [NREG];
  logic [DW-1:0]      reg_d [NREG];
  logic               reg_en;
  logic [INSTR_W-1:0] prog_q;
  logic [INSTR_W-1:0] prog_d;
  logic               prog_en;
  logic [NREG*DW-1:0] reg_flat;

  instr_t             ins;

  // Operand slots: 0 = Ra, 1 = Rb, 2 = first source, 3 = second source
  logic [SEL_W-1:0]   slot_idx  [NSLOT];
  logic [DW-1:0]      slot_val  [NSLOT];
  logic [NSLOT-1:0]   slot_vld;
  logic [NSLOT-1:0]   slot_need;

  logic               take_then;
  op_e                sel_op;
  logic [SEL_W-1:0]   sel_dst;
  logic               dst_is_link;
  logic               dst_free;
  logic               writes;
  logic               inputs_ok;
  logic               fire;
  logic [DW-1:0]      alu_y;
  logic [NLINK-1:0]   link_load;
  logic [NLINK-1:0]   consume;
  logic               host_wr_ok;

  assign ins        = instr_t'(prog_q);
  assign host_wr_ok = host_we && !run_en;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_flat
      assign reg_flat[g*DW +: DW] = reg_q[g];
    end
  endgenerate

  // Compare operands never depend on the branch taken
  assign slot_idx[0] = ins.ra;
  assign slot_idx[1] = ins.rb;

  always_comb begin
    logic signed [DW-1:0] ca;
    logic signed [DW-1:0] cb;
    ca = slot_val[0];
    cb = slot_val[1];
    case (ins.tst)
      TST_EQ:  take_then = (ca == cb);
      TST_LT:  take_then = (ca <  cb);
      TST_GT:  take_then = (ca >  cb);
      default: take_then = (ca != cb);
    endcase
  end

  always_comb begin
    if (take_then) begin
      sel_op      = ins.then_op;
      sel_dst     = ins.rc;
      slot_idx[2] = ins.rd;
      slot_idx[3] = ins.re;
    end else begin
      sel_op      = ins.else_op;
      sel_dst     = ins.rf;
      slot_idx[2] = ins.rg;
      slot_idx[3] = ins.rh;
    end
  end

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      cell_opsel #(
        .DW    (DW),
        .NREG  (NREG),
        .NLINK (NLINK)
      ) opsel_i (
        .idx       (slot_idx[s]),
        .reg_flat  (reg_flat),
        .lin_data  (link_in_data),
        .lin_valid (link_in_valid),
        .val       (slot_val[s]),
        .vld       (slot_vld[s])
      );
    end
  endgenerate

  assign slot_need = {op_uses_second(sel_op), op_uses_first(sel_op), 2'b11};
  assign writes    = op_uses_first(sel_op);
  assign inputs_ok = &(~slot_need | slot_vld);

  always_comb begin
    dst_is_link = 1'b0;
    dst_free    = 1'b1;
    for (int k = 0; k < NLINK; k++) begin
      if (sel_dst == SEL_W'(NREG + k)) begin
        dst_is_link = 1'b1;
        dst_free    = !link_out_valid[k];
      end
    end
  end

  assign fire = run_en && inputs_ok && (!writes || dst_free);

  cell_alu #(.DW(DW)) alu_i (
    .op (sel_op),
    .a  (slot_val[2]),
    .b  (slot_val[3]),
    .y  (alu_y)
  );

  // Link input consumption: one pulse per referenced link per step
  always_comb begin
    consume = '0;
    for (int k = 0; k < NLINK; k++) begin
      for (int s = 0; s < NSLOT; s++) begin
        if (slot_need[s] && slot_idx[s] == SEL_W'(NREG + k)) begin
          consume[k] = 1'b1;
        end
      end
    end
  end

  assign link_in_ready = fire ? consume : '0;

  // Link outputs
  generate
    for (genvar k = 0; k < NLINK; k++) begin : g_lout
      assign link_load[k] = fire && writes && (sel_dst == SEL_W'(NREG + k));
      cell_link_out #(.DW(DW)) lout_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (link_load[k]),
        .load_data (alu_y),
        .ready     (link_out_ready[k]),
        .valid     (link_out_valid[k]),
        .data      (link_out_data[k*DW +: DW])
      );
    end
  endgenerate

  // Data register next state
  always_comb begin
    for (int k = 0; k < NREG; k++) begin
      reg_d[k] = reg_q[k];
    end
    reg_en = 1'b0;
    if (host_wr_ok) begin
      for (int k = 0; k < NREG; k++) begin
        if (host_addr == AW'(k)) begin
          reg_d[k] = host_wdata;
          reg_en   = 1'b1;
        end
      end
    end else if (fire && writes && !dst_is_link) begin
      for (int k = 0; k < NREG; k++) begin
        if (sel_dst == SEL_W'(k)) begin
          reg_d[k] = alu_y;
          reg_en   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) begin
        reg_q[k] <= '0;
      end
    end else if (reg_en) begin
      for (int k = 0; k < NREG; k++) begin
        reg_q[k] <= reg_d[k];
      end
    end
  end

  // Program register next state
  assign prog_en = host_wr_ok && (host_addr == PROG_ADDR);
  assign prog_d  = host_wdata[INSTR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= IDLE_WORD;
    end else if (prog_en) begin
      prog_q <= prog_d;
    end
  end

  // Host read
  always_comb begin
    host_rdata = '0;
    for (int k = 0; k < NREG; k++) begin
      if (host_addr == AW'(k)) begin
        host_rdata = reg_q[k];
      end
    end
    if (host_addr == PROG_ADDR) begin
      host_rdata = DW'(prog_q);
    end
  end

endmodule

// File: rtl/cond_cell_chk.sv
module cond_cell_chk #(
  parameter int DW    = 32,
  parameter int NLINK = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                run_en,
  input logic [NLINK-1:0]    link_in_valid,
  input logic [NLINK-1:0]    link_in_ready,
  input logic [NLINK*DW-1:0] link_out_data,
  input logic [NLINK-1:0]    link_out_valid,
  input logic [NLINK-1:0]    link_out_ready
);

  // R9
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_in_ready & ~link_in_valid) == '0);

  // R11
  halt_no_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> (link_in_ready == '0));

  // R11
  halt_no_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ((link_out_valid & ~$past(link_out_valid)) == '0));

  generate
    for (genvar k = 0; k < NLINK; k++) begin : g_hold
      // R10
      out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_out_valid[k] && !link_out_ready[k]) |=>
          (link_out_valid[k] && $stable(link_out_data[k*DW +: DW])));
    end
  endgenerate

endmodule

bind cond_cell cond_cell_chk #(.DW(DW), .NLINK(NLINK)) chk_i (.*);

// File: tb/cond_cell_tb_top.sv
`timescale 1ns/1ps
module cond_cell_tb_top;

  logic         clk;
  logic         rst_n;
  logic         run_en;
  logic [3:0]   host_addr;
  logic [31:0]  host_wdata;
  logic         host_we;
  logic [31:0]  host_rdata;
  logic [127:0] link_in_data;
  logic [3:0]   link_in_valid;
  logic [3:0]   link_in_ready;
  logic [127:0] link_out_data;
  logic [3:0]   link_out_valid;
  logic [3:0]   link_out_ready;

  int n_chk;
  int n_fail;
  bit done;

  cond_cell dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .run_en         (run_en),
    .host_addr      (host_addr),
    .host_wdata     (host_wdata),
    .host_we        (host_we),
    .host_rdata     (host_rdata),
    .link_in_data   (link_in_data),
    .link_in_valid  (link_in_valid),
    .link_in_ready  (link_in_ready),
    .link_out_data  (link_out_data),
    .link_out_valid (link_out_valid),
    .link_out_ready (link_out_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int t, input int ra, input int rb,
                                     input int rc, input int rd, input int re,
                                     input int rf, input int rg, input int rh,
                                     input int top, input int eop);
    return {t[1:0], ra[2:0], rb[2:0], rc[2:0], rd[2:0], re[2:0],
            rf[2:0], rg[2:0], rh[2:0], top[2:0], eop[2:0]};
  endfunction

  task automatic host_wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    host_addr  = addr[3:0];
    host_wdata = data;
    host_we    = 1'b1;
    @(negedge clk);
    host_we    = 1'b0;
  endtask

  task automatic host_rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    host_addr = addr[3:0];
    #1;
    data = host_rdata;
  endtask

  task automatic run_steps(input int n);
    @(negedge clk);
    run_en = 1'b1;
    repeat (n) @(negedge clk);
    run_en = 1'b0;
  endtask

  function automatic logic [31:0] alu_ref(input int op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [31:0] keep);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a * b;
      3: return a & b;
      4: return a | b;
      5: return a ^ b;
      6: return a;
      default: return keep;
    endcase
  endfunction

  function automatic bit cmp_ref(input int t, input int a, input int b);
    case (t)
      0: return a == b;
      1: return a < b;
      2: return a > b;
      default: return a != b;
    endcase
  endfunction

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] rd;
    int vals[5];
    logic [31:0] pa[4];
    logic [31:0] pb[4];
    vals = '{-2, -1, 0, 1, 2};
    pa = '{32'd5, 32'hFFFF_FFF9, 32'h1234_5678, 32'hFFFF_FFFF};
    pb = '{32'd3, 32'd2,         32'h9ABC_DEF0, 32'hFFFF_FFFF};
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; run_en = 1'b0; host_addr = '0; host_wdata = '0; host_we = 1'b0;
    link_in_data = '0; link_in_valid = '0; link_out_ready = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int k = 0; k < 4; k++) begin
      host_rd(k, rd);
      check("R1 data reg", rd, 32'h0);
    end
    host_rd(8, rd);
    check("R1 program", rd, 32'h0000_003F);
    check("R1 out valid", {28'h0, link_out_valid}, 32'h0);
    check("R1 in ready", {28'h0, link_in_ready}, 32'h0);

    // R2 host write/read while halted
    host_wr(1, 32'hCAFE_0001);
    host_rd(1, rd);
    check("R2 reg write", rd, 32'hCAFE_0001);
    host_rd(5, rd);
    check("R2 unmapped read", rd, 32'h0);

    // R3 host writes ignored while running (idle program)
    @(negedge clk);
    run_en = 1'b1;
    host_wr(0, 32'h0000_1234);
    host_wr(8, 32'h0123_4567);
    @(negedge clk);
    run_en = 1'b0;
    host_rd(0, rd);
    check("R3 reg unchanged", rd, 32'h0);
    host_rd(8, rd);
    check("R3 program unchanged", rd, 32'h0000_003F);

    // R4 compare sweep: THEN R2=R0+R1, ELSE R3=R0-R1
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          logic [31:0] e2, e3, r2, r3;
          host_wr(0, vals[i]);
          host_wr(1, vals[j]);
          host_wr(2, 32'hAAAA_0000);
          host_wr(3, 32'hBBBB_0000);
          host_wr(8, mk(t, 0, 1, 2, 0, 1, 3, 0, 1, 0, 1));
          host_rd(8, rd);
          check("R2 program write", rd, mk(t, 0, 1, 2, 0, 1, 3, 0, 1, 0, 1));
          run_steps(2);
          host_rd(2, r2);
          host_rd(3, r3);
          e2 = 32'hAAAA_0000;
          e3 = 32'hBBBB_0000;
          if (cmp_ref(t, vals[i], vals[j])) e2 = vals[i] + vals[j];
          else                              e3 = vals[i] - vals[j];
          check("R4 then dest", r2, e2);
          check("R4 else dest", r3, e3);
        end
      end
    end

    // R5 R6 opcode sweep: THEN R2 = R0 op R1, test R0==R0
    for (int op = 0; op < 8; op++) begin
      for (int p = 0; p < 4; p++) begin
        host_wr(0, pa[p]);
        host_wr(1, pb[p]);
        host_wr(2, 32'h5555_5555);
        host_wr(8, mk(0, 0, 0, 2, 0, 1, 0, 0, 0, op, 7));
        run_steps(1);
        host_rd(2, rd);
        check(op < 6 ? "R5 alu op" : "R6 pass/nop", rd,
              alu_ref(op, pa[p], pb[p], 32'h5555_5555));
      end
    end

    // R7 repeated execution: R0 = R0 + R1 for 4 steps
    host_wr(0, 32'd5);
    host_wr(1, 32'd3);
    host_wr(8, mk(0, 1, 1, 0, 0, 1, 0, 0, 0, 0, 7));
    run_steps(4);
    host_rd(0, rd);
    check("R7 step count", rd, 32'd17);

    // R8 read before write: R0 = R0 + R0 for 3 steps
    host_wr(0, 32'd1);
    host_wr(8, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 7));
    run_steps(3);
    host_rd(0, rd);
    check("R8 self update", rd, 32'd8);

    // R9 R10 links: THEN link0 out = link1 in + R0
    host_wr(0, 32'd7);
    host_wr(8, mk(0, 0, 0, 4, 5, 0, 0, 0, 0, 0, 7));
    @(negedge clk);
    run_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 stall no output", {28'h0, link_out_valid}, 32'h0);
    check("R9 stall no ready", {28'h0, link_in_ready}, 32'h0);
    link_in_data[63:32] = 32'd100;
    link_in_valid[1] = 1'b1;
    #1;
    check("R9 consume ready", {28'h0, link_in_ready}, 32'h2);
    @(negedge clk);
    link_in_valid[1] = 1'b0;
    check("R10 out valid", {28'h0, link_out_valid}, 32'h1);
    check("R10 out data", link_out_data[31:0], 32'd107);
    link_in_data[63:32] = 32'd200;
    link_in_valid[1] = 1'b1;
    #1;
    check("R10 busy dest stalls", {28'h0, link_in_ready}, 32'h0);
    @(negedge clk);
    check("R10 hold data", link_out_data[31:0], 32'd107);
    link_out_ready[0] = 1'b1;
    @(negedge clk);
    link_out_ready[0] = 1'b0;
    #1;
    check("R10 drained", {28'h0, link_out_valid}, 32'h0);
    check("R9 consume second", {28'h0, link_in_ready}, 32'h2);
    @(negedge clk);
    link_in_valid[1] = 1'b0;
    check("R10 second data", link_out_data[31:0], 32'd207);
    check("R10 second valid", {28'h0, link_out_valid}, 32'h1);
    link_out_ready[0] = 1'b1;
    @(negedge clk);
    link_out_ready[0] = 1'b0;
    run_en = 1'b0;

    // R11 halted cell ignores a pending link input
    link_in_data[63:32] = 32'd50;
    link_in_valid[1] = 1'b1;
    #1;
    check("R11 no consume", {28'h0, link_in_ready}, 32'h0);
    repeat (3) @(negedge clk);
    check("R11 no emit", {28'h0, link_out_valid}, 32'h0);
    link_in_valid[1] = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule